// File: doc/BRIEF.md
# Vectored Interrupt Offset Generator

This block turns the current interrupt state into the byte offset that a processor adds to its exception base when it enters an interrupt handler. On a one-cycle start pulse it samples the eight pending interrupt lines, a special-vector select bit, a six-bit vector-spacing field and two mode bits. One cycle later it presents the offset with a one-cycle valid pulse. The mode bits select internal vectored mode or external-controller mode.

With neither mode enabled, the block returns either the general exception offset or the dedicated interrupt offset, as the special-vector bit chooses. In internal vectored mode the vector number is the position of the lowest-numbered pending line. In external-controller mode the eight pending lines carry a binary vector number from an outside controller. In both vectored modes the vector is multiplied by the programmed spacing and added to the dedicated interrupt offset.

A small state machine tracks whether a result is being presented. It has two states: `ST_IDLE` (no result) and `ST_PRESENT` (result valid this cycle). It has three transitions: `T_ACCEPT` from `ST_IDLE` to `ST_PRESENT` on start, `T_CHAIN` from `ST_PRESENT` to `ST_PRESENT` on a further start, and `T_RETIRE` from `ST_PRESENT` to `ST_IDLE` when start is low.

Top module: `irq_vec_offset`

## Requirements
- R1: While and right after reset, `res_valid` is 0 and `res_offset` is 0.
- R2: `res_valid` is 1 in exactly those cycles that directly follow a cycle with `req_start` high.
- R3: With `mode_int` = 0, `mode_ext` = 0 and `sel_special` = 0, the offset is 0x180.
- R4: With `mode_int` = 0, `mode_ext` = 0 and `sel_special` = 1, the offset is 0x200.
- R5: With `mode_int` = 1, the offset is 0x200 + v × step. Here v is the index of the lowest set bit of `irq_pend`, with bit 0 winning over bits 1 to 7, and step = `vec_space` × 32.
- R6: With `mode_int` = 1 and `irq_pend` = 0, v is 8, so the offset is 0x200 + 8 × step, and `res_valid` still pulses.
- R7: With `mode_int` = 0 and `mode_ext` = 1, v is the unsigned value of `irq_pend`, and the offset is 0x200 + v × step.
- R8: In either vectored mode, `sel_special` has no effect. A `vec_space` of 0 gives an offset of 0x200 for any vector.
- R9: When both `mode_int` and `mode_ext` are 1, internal vectored mode applies.
- R10: In a cycle without `req_start`, the inputs are ignored: `res_offset` holds the value it had.
- R11: Starts on consecutive cycles each produce their own result, one cycle after each start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle request to compute an offset |
| irq_pend | input | 8 | Pending interrupt lines, or the external vector number |
| sel_special | input | 1 | Selects the dedicated interrupt offset when not vectored |
| vec_space | input | 6 | Vector spacing in units of 32 bytes |
| mode_int | input | 1 | Internal vectored mode enable |
| mode_ext | input | 1 | External-controller vector mode enable |
| res_valid | output | 1 | One-cycle valid pulse for the result |
| res_offset | output | 20 | Computed handler offset |

## Verification
Two functions can fall in the same cycle: presenting a finished result and accepting a new request. This happens when `req_start` is high in the cycle where `res_valid` is already high (transition `T_CHAIN`). The bench provokes it with back-to-back requests that use different modes and pending patterns. In the overlap cycle it checks that the offset still shows the first request's result. In the following cycle it checks that the offset shows the second request's result, with `res_valid` still high.

// File: rtl/ivo_pkg.sv
package ivo_pkg;

    localparam int OFFSET_GENERAL = 32'h180;
    localparam int OFFSET_VECTOR  = 32'h200;
    localparam int SPACE_SHIFT    = 5;

    typedef enum logic [1:0] {
        MODE_LEGACY   = 2'd0,
        MODE_SPECIAL  = 2'd1,
        MODE_INTERNAL = 2'd2,
        MODE_EXTERNAL = 2'd3
    } vec_mode_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } ivo_state_e;

    function automatic vec_mode_e decode_mode(input logic m_int,
                                              input logic m_ext,
                                              input logic special);
        if (m_int)
            return MODE_INTERNAL;
        else if (m_ext)
            return MODE_EXTERNAL;
        else if (special)
            return MODE_SPECIAL;
        else
            return MODE_LEGACY;
    endfunction

endpackage

// File: rtl/ivo_lowest_set.sv
module ivo_lowest_set #(
    parameter int LINES = 8,
    parameter int IDX_W = $clog2(LINES + 1)
) (
    input  logic [LINES-1:0] lines,
    output logic [IDX_W-1:0] index
);
    // Prefix "no lower line set" chain, one stage per line.
    logic [LINES:0] none_below;
    logic [LINES-1:0] first_hot;

    assign none_below[0] = 1'b1;

    for (genvar g = 0; g < LINES; g++) begin : g_chain
        assign first_hot[g]    = lines[g] & none_below[g];
        assign none_below[g+1] = none_below[g] & ~lines[g];
    end

    always_comb begin
        index = IDX_W'(LINES);
        for (int i = 0; i < LINES; i++) begin
            if (first_hot[i])
                index = IDX_W'(i);
        end
    end

endmodule

// File: rtl/ivo_scale.sv
module ivo_scale #(
    parameter int VEC_W = 8,
    parameter int VS_W  = 6,
    parameter int OFF_W = VEC_W + VS_W + 6
) (
    input  logic [VEC_W-1:0] vec,
    input  logic [VS_W-1:0]  space,
    output logic [OFF_W-1:0] offset
);
    import ivo_pkg::*;

    localparam int STEP_W = VS_W + SPACE_SHIFT;

    logic [STEP_W-1:0] step;

    assign step   = {space, {SPACE_SHIFT{1'b0}}};
    assign offset = OFF_W'(OFFSET_VECTOR) + (OFF_W'(vec) * OFF_W'(step));

endmodule

// File: rtl/irq_vec_offset.sv
module irq_vec_offset #(
    parameter int PEND_W = 8,
    parameter int VS_W   = 6,
    parameter int OFF_W  = PEND_W + VS_W + 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [PEND_W-1:0] irq_pend,
    input  logic              sel_special,
    input  logic [VS_W-1:0]   vec_space,
    input  logic              mode_int,
    input  logic              mode_ext,
    output logic              res_valid,
    output logic [OFF_W-1:0]  res_offset
);
    import ivo_pkg::*;

    localparam int IDX_W = $clog2(PEND_W + 1);

    ivo_state_e        state_q, state_d;
    vec_mode_e         mode;
    logic [IDX_W-1:0]  low_idx;
    logic [PEND_W-1:0] vec_num;
    logic [OFF_W-1:0]  scaled_off;
    logic [OFF_W-1:0]  next_off;

    ivo_lowest_set #(.LINES(PEND_W), .IDX_W(IDX_W)) u_lowest (
        .lines (irq_pend),
        .index (low_idx)
    );

    ivo_scale #(.VEC_W(PEND_W), .VS_W(VS_W), .OFF_W(OFF_W)) u_scale (
        .vec    (vec_num),
        .space  (vec_space),
        .offset (scaled_off)
    );

    assign mode = decode_mode(mode_int, mode_ext, sel_special);

    always_comb begin
        unique case (mode)
            MODE_INTERNAL: vec_num = PEND_W'(low_idx);
            MODE_EXTERNAL: vec_num = irq_pend;
            default:       vec_num = '0;
        endcase
    end

    always_comb begin
        unique case (mode)
            MODE_LEGACY:  next_off = OFF_W'(OFFSET_GENERAL);
            MODE_SPECIAL: next_off = OFF_W'(OFFSET_VECTOR);
            default:      next_off = scaled_off;
        endcase
    end

    // Next-state logic: T_ACCEPT, T_CHAIN, T_RETIRE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_start) state_d = ST_PRESENT;
            ST_PRESENT: state_d = req_start ? ST_PRESENT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Output register: captures the offset only on an accepted request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_offset <= '0;
        else if (req_start)
            res_offset <= next_off;
    end

    assign res_valid = (state_q == ST_PRESENT);

endmodule

// File: rtl/ivo_chk.sv
module ivo_chk #(
    parameter int PEND_W = 8,
    parameter int VS_W   = 6,
    parameter int OFF_W  = PEND_W + VS_W + 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_start,
    input logic [PEND_W-1:0] irq_pend,
    input logic              sel_special,
    input logic [VS_W-1:0]   vec_space,
    input logic              mode_int,
    input logic              mode_ext,
    input logic              res_valid,
    input logic [OFF_W-1:0]  res_offset
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && res_offset == '0));

    a_r2_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        req_start |=> res_valid);

    a_r2_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_start |=> !res_valid);

    a_r3_general_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && !mode_int && !mode_ext && !sel_special)
        |=> res_offset == OFF_W'(32'h180));

    a_r4_special_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && !mode_int && !mode_ext && sel_special)
        |=> res_offset == OFF_W'(32'h200));

    a_r6_empty_internal: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && mode_int && irq_pend == '0)
        |=> res_offset == OFF_W'(32'h200 + 8 * 32 * int'($past(vec_space))));

    a_r8_zero_space: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && (mode_int || mode_ext) && vec_space == '0)
        |=> res_offset == OFF_W'(32'h200));

    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_start |=> $stable(res_offset));

endmodule

bind irq_vec_offset ivo_chk #(.PEND_W(PEND_W), .VS_W(VS_W), .OFF_W(OFF_W)) chk_i (.*);

// File: tb/irq_vec_offset_tb_top.sv
module irq_vec_offset_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic [7:0]  irq_pend = '0;
    logic        sel_special = 1'b0;
    logic [5:0]  vec_space = '0;
    logic        mode_int = 1'b0;
    logic        mode_ext = 1'b0;
    logic        res_valid;
    logic [19:0] res_offset;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    irq_vec_offset dut_i (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .irq_pend(irq_pend),
        .sel_special(sel_special), .vec_space(vec_space), .mode_int(mode_int),
        .mode_ext(mode_ext), .res_valid(res_valid), .res_offset(res_offset)
    );

    function automatic int lowest_idx(input logic [7:0] p);
        for (int i = 7; i >= 0; i--) begin
            if (p[i]) lowest_idx = i;
        end
        if (p == 0) lowest_idx = 8;
    endfunction

    function automatic int exp_off(input logic mi, input logic me, input logic sp,
                                   input logic [7:0] p, input logic [5:0] vs);
        int v;
        if (mi)      v = lowest_idx(p);
        else if (me) v = int'(p);
        else         return sp ? 32'h200 : 32'h180;
        return 32'h200 + v * int'(vs) * 32;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic mi, input logic me, input logic sp,
                         input logic [7:0] p, input logic [5:0] vs, input logic st);
        mode_int = mi; mode_ext = me; sel_special = sp;
        irq_pend = p;  vec_space = vs; req_start = st;
    endtask

    // One request, checked in the cycle after the start.
    task automatic one_req(input string tag, input logic mi, input logic me,
                           input logic sp, input logic [7:0] p, input logic [5:0] vs);
        drive(mi, me, sp, p, vs, 1'b1);
        @(negedge clk);
        req_start = 1'b0;
        check({tag, " valid"}, int'(res_valid), 1);
        check(tag, int'(res_offset), exp_off(mi, me, sp, p, vs));
        @(negedge clk);
        check("R2 valid drops", int'(res_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        int prev;
        logic [7:0] p;
        logic [5:0] vs;
        logic mi, me, sp;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 reset valid", int'(res_valid), 0);
        check("R1 reset offset", int'(res_offset), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset valid", int'(res_valid), 0);
        check("R1 after reset offset", int'(res_offset), 0);

        one_req("R3 general", 1'b0, 1'b0, 1'b0, 8'hFF, 6'd5);
        one_req("R4 special", 1'b0, 1'b0, 1'b1, 8'h01, 6'd5);
        one_req("R5 lowest bit0", 1'b1, 1'b0, 1'b0, 8'hFF, 6'd3);
        one_req("R5 lowest bit7", 1'b1, 1'b0, 1'b0, 8'h80, 6'd63);
        one_req("R5 lowest bit3", 1'b1, 1'b0, 1'b1, 8'hA8, 6'd1);
        one_req("R6 empty internal", 1'b1, 1'b0, 1'b0, 8'h00, 6'd2);
        one_req("R7 external max", 1'b0, 1'b1, 1'b0, 8'hFF, 6'd63);
        one_req("R7 external zero", 1'b0, 1'b1, 1'b1, 8'h00, 6'd9);
        one_req("R8 zero space", 1'b0, 1'b1, 1'b0, 8'h77, 6'd0);
        one_req("R9 both modes", 1'b1, 1'b1, 1'b0, 8'h30, 6'd4);

        // R10: inputs change without start, output must hold.
        prev = int'(res_offset);
        drive(1'b0, 1'b1, 1'b0, 8'h55, 6'd7, 1'b0);
        @(negedge clk);
        check("R10 hold offset", int'(res_offset), prev);
        check("R10 no valid", int'(res_valid), 0);

        // R11: back-to-back requests overlap presentation and acceptance.
        drive(1'b0, 1'b1, 1'b0, 8'h10, 6'd2, 1'b1);
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b0, 8'h04, 6'd8, 1'b1);
        check("R11 first valid", int'(res_valid), 1);
        check("R11 first offset", int'(res_offset), exp_off(1'b0, 1'b1, 1'b0, 8'h10, 6'd2));
        @(negedge clk);
        req_start = 1'b0;
        check("R11 second valid", int'(res_valid), 1);
        check("R11 second offset", int'(res_offset), exp_off(1'b1, 1'b0, 1'b0, 8'h04, 6'd8));
        @(negedge clk);

        // Random traffic with occasional chained starts.
        for (int k = 0; k < 300; k++) begin
            mi = ($urandom % 3) == 0;
            me = ($urandom % 2) == 0;
            sp = $urandom % 2;
            p  = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
            vs = 6'($urandom);
            drive(mi, me, sp, p, vs, 1'b1);
            @(negedge clk);
            req_start = (($urandom % 4) == 0);
            check("R5 R7 random valid", int'(res_valid), 1);
            check("R5 R7 random offset", int'(res_offset), exp_off(mi, me, sp, p, vs));
            if (!req_start) begin
                @(negedge clk);
                check("R2 random idle", int'(res_valid), 0);
            end
        end
        req_start = 1'b0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule